// File: doc/BRIEF.md
# Prioritised Interrupt Trap Controller

This block receives an external interrupt request as a 4-bit encoded level and decides whether the processor must take a trap. Level 0 means that nothing is requested. Levels 1 to 14 are maskable. They pass only while traps are enabled and the level is strictly above the 4-bit processor interrupt level. Level 15 cannot be masked. The request first crosses a two-flop synchroniser, and the block acts on it only after the synchronised value has held for two consecutive cycles.

When the block accepts a trap it captures the current and next program counters and raises a one-cycle pipeline flush. It also saves the previous supervisor bit, switches to supervisor mode and clears trap-enable. At the same time it presents a handler address built from the upper bits of the trap base register, an 8-bit trap type of 0x10 plus the level, and four zero bits at the bottom. A return-from-trap pulse restores the saved supervisor bit, sets trap-enable and presents the saved addresses with a one-cycle resume strobe.

The controller has five named states. BOOT is entered from reset: the block is in supervisor mode, traps are disabled and only level 15 is accepted. RUN is normal operation with traps enabled. FLUSH is the cycle in which the trap is signalled. HANDLER waits for the return. RETURN is the cycle in which the resume strobe is raised. The transitions are:
- take: BOOT or RUN to FLUSH.
- enter: FLUSH to HANDLER.
- leave: HANDLER or BOOT to RETURN, on a return pulse.
- resume: RETURN to RUN.

Top module: `irq_trap_ctrl`

## Requirements
- R1: After reset the block is in BOOT: `supervisor`=1, `traps_enabled`=0, `flush`=0, `resume`=0. The saved supervisor bit is 0 (user), so a return from BOOT enters user mode.
- R2: Level 0 never causes a trap. Levels 1–14 cause a trap only in RUN with `traps_enabled`=1 and level > `pil`. A level equal to `pil` is not taken, and in BOOT levels 1–14 are ignored.
- R3: Level 15 is taken in BOOT and in RUN whatever the values of `pil` and `traps_enabled`.
- R4: A level that changes at the input is acted on no earlier than the fourth rising edge after the change, with `flush` high after that edge. A level that changes on every cycle is never taken.
- R5: When a trap is taken, `flush` is high for exactly one cycle. In that cycle `supervisor`=1 and `traps_enabled`=0.
- R6: `resume_pc` and `resume_npc` hold the `cur_pc` and `next_pc` values present at the edge where the trap was accepted.
- R7: While `flush` is high, `trap_type` = 0x10 + level and `handler_pc` = {`trap_base`[31:12], `trap_type`, 4'b0}.
- R8: A `rett` pulse in HANDLER or BOOT gives `resume`=1 for exactly the next cycle. From that cycle `supervisor` equals its value before the trap and `traps_enabled`=1.
- R9: A `rett` pulse in RUN is ignored: no `resume`, and `supervisor` and `traps_enabled` keep their values.
- R10: A request of level 15 that arrives while in HANDLER is held off. It is taken on the second edge after the RETURN cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_level | input | 4 | Encoded external interrupt level, asynchronous |
| pil | input | 4 | Processor interrupt level; maskable levels must exceed it |
| trap_base | input | 32 | Trap base register; bits 31:12 are used |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the next instruction |
| rett | input | 1 | Return-from-trap pulse |
| flush | output | 1 | One-cycle pipeline flush when a trap is taken |
| handler_pc | output | 32 | Handler address for the trap |
| trap_type | output | 8 | Trap type of the trap taken |
| supervisor | output | 1 | Supervisor mode bit |
| traps_enabled | output | 1 | Global trap-enable bit |
| resume | output | 1 | One-cycle strobe: continue at the resume addresses |
| resume_pc | output | 32 | Saved current address |
| resume_npc | output | 32 | Saved next address |

## Verification
Each result has a fixed due cycle:
- A new input level shows as `flush`, `trap_type` and `handler_pc` after the fourth rising edge. Two edges go to the synchroniser, one to the stability flop and one to the state register.
- A `rett` pulse shows as `resume` and the restored mode bits after the first edge.
- A level 15 request held off during HANDLER shows as `flush` two edges after the RETURN cycle.

The bench drives every input on the falling edge, steps a whole number of rising edges, and samples on the following falling edge. It also checks that `flush` is still low one edge before it is due. Negative cases, such as ignored returns, masked levels and toggling levels, are sampled at the cycle where a wrong acceptance would show.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;
    typedef enum logic [2:0] {
        ST_BOOT    = 3'd0,
        ST_RUN     = 3'd1,
        ST_FLUSH   = 3'd2,
        ST_HANDLER = 3'd3,
        ST_RETURN  = 3'd4
    } trap_state_e;
endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
    parameter int LVL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_in,
    output logic [LVL_W-1:0] lvl_out,
    output logic             lvl_steady
);
    logic [LVL_W-1:0] chain_q [SYNC_STAGES];
    logic [LVL_W-1:0] hold_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= lvl_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= chain_q[SYNC_STAGES-1];
    end

    assign lvl_out    = chain_q[SYNC_STAGES-1];
    assign lvl_steady = (chain_q[SYNC_STAGES-1] == hold_q);
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic             lvl_steady,
    input  logic [LVL_W-1:0] pil,
    input  logic             traps_on,
    input  logic             armed,
    output logic             take
);
    localparam logic [LVL_W-1:0] NMI_LVL = {LVL_W{1'b1}};

    logic is_nmi, maskable_ok;

    always_comb begin
        is_nmi      = (lvl == NMI_LVL);
        maskable_ok = traps_on && (lvl != '0) && (lvl > pil);
        take        = armed && lvl_steady && (is_nmi || maskable_ok);
    end
endmodule

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl
    import irq_trap_pkg::*;
#(
    parameter int          PC_W        = 32,
    parameter int          LVL_W       = 4,
    parameter int          TT_W        = 8,
    parameter int          VEC_SHIFT   = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  TT_IRQ_BASE = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] pil,
    input  logic [PC_W-1:0]  trap_base,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  next_pc,
    input  logic             rett,
    output logic             flush,
    output logic [PC_W-1:0]  handler_pc,
    output logic [TT_W-1:0]  trap_type,
    output logic             supervisor,
    output logic             traps_enabled,
    output logic             resume,
    output logic [PC_W-1:0]  resume_pc,
    output logic [PC_W-1:0]  resume_npc
);
    localparam int              BASE_W  = PC_W - TT_W - VEC_SHIFT;
    localparam logic [LVL_W-1:0] NMI_LVL = {LVL_W{1'b1}};
    localparam logic [TT_W-1:0]  NMI_TT  = TT_W'(TT_IRQ_BASE) + TT_W'(NMI_LVL);

    trap_state_e state_q, state_d;

    logic [LVL_W-1:0]  s_lvl;
    logic              s_steady;
    logic              armed, take, leave;
    logic              super_q, prev_super_q, et_q;
    logic [PC_W-1:0]   pc_q, npc_q;
    logic [TT_W-1:0]   tt_q;
    logic [BASE_W-1:0] base_q;

    irq_level_sync #(.LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_in     (irq_level),
        .lvl_out    (s_lvl),
        .lvl_steady (s_steady)
    );

    assign armed = (state_q == ST_BOOT) || (state_q == ST_RUN);

    irq_accept #(.LVL_W(LVL_W)) u_accept (
        .lvl        (s_lvl),
        .lvl_steady (s_steady),
        .pil        (pil),
        .traps_on   (et_q),
        .armed      (armed),
        .take       (take)
    );

    assign leave = rett && ((state_q == ST_HANDLER) || (state_q == ST_BOOT));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:    if (take) state_d = ST_FLUSH;
                        else if (leave) state_d = ST_RETURN;
            ST_RUN:     if (take) state_d = ST_FLUSH;
            ST_FLUSH:   state_d = ST_HANDLER;
            ST_HANDLER: if (leave) state_d = ST_RETURN;
            ST_RETURN:  state_d = ST_RUN;
            default:    state_d = ST_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // status bits and trap context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            super_q      <= 1'b1;
            prev_super_q <= 1'b0;
            et_q         <= 1'b0;
            pc_q         <= '0;
            npc_q        <= '0;
            tt_q         <= '0;
            base_q       <= '0;
        end else if (take) begin
            prev_super_q <= super_q;
            super_q      <= 1'b1;
            et_q         <= 1'b0;
            pc_q         <= cur_pc;
            npc_q        <= next_pc;
            tt_q         <= TT_W'(TT_IRQ_BASE) + TT_W'(s_lvl);
            base_q       <= trap_base[PC_W-1 -: BASE_W];
        end else if (leave) begin
            super_q      <= prev_super_q;
            et_q         <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        flush         = (state_q == ST_FLUSH);
        resume        = (state_q == ST_RETURN);
        handler_pc    = {base_q, tt_q, {VEC_SHIFT{1'b0}}};
        trap_type     = tt_q;
        supervisor    = super_q;
        traps_enabled = et_q;
        resume_pc     = pc_q;
        resume_npc    = npc_q;
    end

    a_r5_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    a_r5_mode_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (supervisor && !traps_enabled));

    a_r3_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && s_steady && s_lvl == NMI_LVL) |=> flush);

    a_r2_maskable_needs_et: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && trap_type != NMI_TT) |-> $past(traps_enabled));

    a_r8_resume_after_rett: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (traps_enabled && $past(rett)));

    a_r9_run_rett_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && rett && !take) |=> (!resume && $stable(supervisor)));
endmodule

// File: tb/irq_trap_ctrl_test.sv
`timescale 1ns/1ps
module irq_trap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_level = 4'd0;
    logic [3:0]  pil = 4'd0;
    logic [31:0] trap_base = 32'hABCD_E123;
    logic [31:0] cur_pc = 32'h0;
    logic [31:0] next_pc = 32'h4;
    logic        rett = 1'b0;
    logic        flush, supervisor, traps_enabled, resume;
    logic [31:0] handler_pc, resume_pc, resume_npc;
    logic [7:0]  trap_type;

    int n_chk = 0;
    int n_err = 0;

    irq_trap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .pil(pil),
        .trap_base(trap_base), .cur_pc(cur_pc), .next_pc(next_pc), .rett(rett),
        .flush(flush), .handler_pc(handler_pc), .trap_type(trap_type),
        .supervisor(supervisor), .traps_enabled(traps_enabled), .resume(resume),
        .resume_pc(resume_pc), .resume_npc(resume_npc)
    );

    always #4 clk = ~clk;

    // {pil, level, expect_take}
    localparam logic [8:0] VEC [8] = '{
        {4'd0,  4'd1,  1'b1},
        {4'd5,  4'd5,  1'b0},
        {4'd5,  4'd6,  1'b1},
        {4'd14, 4'd14, 1'b0},
        {4'd14, 4'd15, 1'b1},
        {4'd15, 4'd15, 1'b1},
        {4'd3,  4'd0,  1'b0},
        {4'd0,  4'd14, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic do_return(input logic exp_super);
        rett = 1'b1;
        tick(1);
        rett = 1'b0;
        chk("R8 resume strobe", 32'(resume), 32'd1);
        chk("R8 supervisor restored", 32'(supervisor), 32'(exp_super));
        chk("R8 traps enabled", 32'(traps_enabled), 32'd1);
        tick(1);
        chk("R8 resume one cycle", 32'(resume), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 supervisor", 32'(supervisor), 32'd1);
        chk("R1 traps_enabled", 32'(traps_enabled), 32'd0);
        chk("R1 flush", 32'(flush), 32'd0);
        chk("R1 resume", 32'(resume), 32'd0);

        // R2: maskable level ignored in BOOT
        irq_level = 4'd5;
        tick(6);
        chk("R2 boot ignores maskable", 32'(flush), 32'd0);
        irq_level = 4'd0;
        tick(3);

        // leave BOOT into user mode
        do_return(1'b0);

        // R9: rett in RUN ignored
        rett = 1'b1;
        tick(1);
        rett = 1'b0;
        chk("R9 no resume", 32'(resume), 32'd0);
        chk("R9 supervisor kept", 32'(supervisor), 32'd0);
        chk("R9 traps kept", 32'(traps_enabled), 32'd1);

        // acceptance table in RUN
        for (int i = 0; i < 8; i++) begin
            logic [3:0] vp, vl;
            logic       ve;
            string      rq;
            {vp, vl, ve} = VEC[i];
            rq = (vl == 4'd15) ? "R3" : "R2";
            pil = vp;
            irq_level = vl;
            cur_pc  = 32'h0000_4000 + 32'(i) * 32'h10;
            next_pc = cur_pc + 32'h4;
            tick(3);
            chk("R4 not before fourth edge", 32'(flush), 32'd0);
            tick(1);
            chk({rq, " take decision"}, 32'(flush), 32'(ve));
            if (ve) begin
                chk("R7 trap type", 32'(trap_type), 32'h10 + 32'(vl));
                chk("R7 handler address", handler_pc, 32'hABCD_E000 | ((32'h10 + 32'(vl)) << 4));
                chk("R5 supervisor on entry", 32'(supervisor), 32'd1);
                chk("R5 traps off on entry", 32'(traps_enabled), 32'd0);
                chk("R6 saved pc", resume_pc, cur_pc);
                chk("R6 saved npc", resume_npc, next_pc);
                irq_level = 4'd0;
                cur_pc = 32'hDEAD_0000;
                tick(1);
                chk("R5 flush single cycle", 32'(flush), 32'd0);
                chk("R6 saved pc held", resume_pc, 32'h0000_4000 + 32'(i) * 32'h10);
                do_return(1'b0);
            end else begin
                irq_level = 4'd0;
                tick(3);
                chk({rq, " still untaken"}, 32'(flush), 32'd0);
            end
        end

        // R4: level toggling every cycle is never taken
        pil = 4'd0;
        for (int k = 0; k < 10; k++) begin
            irq_level = (k % 2 == 0) ? 4'd3 : 4'd0;
            tick(1);
            chk("R4 toggling not taken", 32'(flush), 32'd0);
        end
        irq_level = 4'd0;
        tick(3);
        chk("R4 toggling settled", 32'(flush), 32'd0);

        // R10: level 15 held off in HANDLER
        irq_level = 4'd5;
        tick(4);
        chk("R10 first trap", 32'(flush), 32'd1);
        irq_level = 4'd15;
        for (int k = 0; k < 6; k++) begin
            tick(1);
            chk("R10 held in handler", 32'(flush), 32'd0);
        end
        rett = 1'b1;
        tick(1);
        rett = 1'b0;
        chk("R10 resume", 32'(resume), 32'd1);
        tick(1);
        chk("R10 not yet", 32'(flush), 32'd0);
        tick(1);
        chk("R10 taken after return", 32'(flush), 32'd1);
        chk("R10 trap type", 32'(trap_type), 32'h1F);
        irq_level = 4'd0;
        tick(1);
        do_return(1'b0);

        // R3: level 15 in BOOT, R8 restores supervisor
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset again", 32'(traps_enabled), 32'd0);
        pil = 4'd15;
        irq_level = 4'd15;
        cur_pc = 32'h0000_0100;
        next_pc = 32'h0000_0104;
        tick(4);
        chk("R3 boot nmi taken", 32'(flush), 32'd1);
        chk("R7 boot nmi handler", handler_pc, 32'hABCD_E1F0);
        chk("R6 boot saved npc", resume_npc, 32'h0000_0104);
        irq_level = 4'd0;
        tick(1);
        do_return(1'b1);

        finish_run();
    end
endmodule